// File: doc/BRIEF.md
# Serial Frame to Character-Display Bus Replayer

This block sits at the display end of a synchronous serial link. A remote sender shifts one frame per display access: a spare bit, a register-select bit, a read/write bit, a data byte and a trailing parity bit. The bits arrive on a data line and are sampled on each rising edge of an external bit clock. The block resamples both lines into its own clock domain, assembles the twelve bits and checks that their parity is even. It then puts a one-bit verdict on a response line that the sender clocks back.

When a frame checks out, the block replays it onto a character-display parallel bus. It first drives register-select, read/write and the data byte. After a setup interval it raises the enable strobe for a programmable number of cycles, and it keeps the bus values steady for a hold interval after the strobe falls. A frame that fails the check never reaches the display bus. Instead it sets an error indicator, and the sender is expected to send that frame again. A bit counter that goes stale, because the bit clock stopped partway through a frame, is cleared after a programmable idle interval.

Top module: `lcd_link_rx`

## Requirements
- R1: After reset, lcd_en, resp_oe, err_led and lcd_db_oe are all 0.
- R2: A frame is 12 bits sent first to last as spare, rs, rw, d7 down to d0, parity, each sampled on a rising ser_clk edge. A good frame appears on lcd_rs, lcd_rw and lcd_db, with d7 on lcd_db[7].
- R3: A frame is good when the count of ones over all 12 bits is even. A bad frame gives no enable pulse and leaves lcd_rs, lcd_rw and lcd_db unchanged.
- R4: After the 12th bit, resp_oe goes high with resp_dat = 1 for a good frame and 0 for a bad one. The next rising ser_clk edge releases resp_oe and is not taken as frame data.
- R5: lcd_rs, lcd_rw and lcd_db are stable for at least SETUP_CYC clocks before lcd_en rises.
- R6: lcd_en stays high for exactly EN_CYC clocks.
- R7: lcd_rs, lcd_rw and lcd_db stay unchanged for at least HOLD_CYC clocks after lcd_en falls.
- R8: Every good frame gives exactly one enable pulse, identical repeated frames included, and no pulse occurs without a good frame.
- R9: If ser_clk shows no rising edge for IDLE_LIM clocks, a partial frame is discarded and a pending response is withdrawn (resp_oe = 0).
- R10: err_led is set by a bad frame and cleared by the next good frame.
- R11: lcd_db_oe follows the inverse of the replayed rw bit: 1 for a write (rw = 0), 0 for a read (rw = 1).
- R12: The spare bit counts toward parity only and has no effect on the display bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Link bit clock from the sender |
| ser_dat | input | 1 | Link serial data from the sender |
| resp_oe | output | 1 | Response line drive enable |
| resp_dat | output | 1 | Response bit: 1 good frame, 0 parity error |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write select |
| lcd_db | output | 8 | Display data byte |
| lcd_db_oe | output | 1 | Data bus drive enable (high on writes) |
| lcd_en | output | 1 | Display enable strobe |
| err_led | output | 1 | Error indicator |

## Verification
The bench builds the block with EN_CYC = 6 and IDLE_LIM = 40. SETUP_CYC and HOLD_CYC keep their defaults of 3 and 2. A bit time of 16 clocks keeps every half-period well inside the shortened idle limit. With the shorter idle limit, both the abandoned partial frame and the unanswered response can be timed out cheaply, and the shorter strobe still lets each display write finish well before the next frame arrives. The non-default strobe width also shows that the width really comes from the parameter.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;          // spare, rs, rw, data
    localparam int WIRE_W  = FRAME_W + 1;         // plus parity
    localparam int CNT_W   = $clog2(WIRE_W);

    typedef struct packed {
        logic              spare;
        logic              rs;
        logic              rw;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_PULSE,
        BUS_HOLD
    } bus_st_e;

    // Even parity over payload and parity bit together
    function automatic logic even_ok(input frame_t f, input logic p);
        return ~(^{f, p});
    endfunction

endpackage

// File: rtl/lcdl_sync.sv
module lcdl_sync (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic bit_rise,
    output logic bit_val
);
    logic [2:0] ck_q;
    logic [1:0] dt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            ck_q <= {ck_q[1:0], ser_clk};
            dt_q <= {dt_q[0], ser_dat};
        end
    end

    // data stage aligned with the clock stage that flags the edge
    assign bit_rise = ck_q[1] & ~ck_q[2];
    assign bit_val  = dt_q[1];
endmodule

// File: rtl/lcdl_frame_rx.sv
module lcdl_frame_rx
    import lcdl_pkg::*;
#(
    parameter int IDLE_LIM = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_rise,
    input  logic   bit_val,
    output logic   frame_done,
    output frame_t frame_q,
    output logic   par_ok,
    output logic   resp_oe,
    output logic   resp_dat
);
    localparam int IW = $clog2(IDLE_LIM + 1);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IW-1:0]      idle_q;
    logic               ack_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            idle_q     <= '0;
            ack_pend   <= 1'b0;
            frame_done <= 1'b0;
            frame_q    <= '0;
            par_ok     <= 1'b0;
            resp_dat   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (bit_rise) begin
                idle_q <= '0;
                if (ack_pend) begin
                    ack_pend <= 1'b0;          // response slot consumed
                end else if (cnt_q == CNT_W'(WIRE_W - 1)) begin
                    frame_q    <= frame_t'(sh_q);
                    par_ok     <= even_ok(frame_t'(sh_q), bit_val);
                    resp_dat   <= even_ok(frame_t'(sh_q), bit_val);
                    frame_done <= 1'b1;
                    ack_pend   <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    sh_q  <= {sh_q[FRAME_W-2:0], bit_val};
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (idle_q == IW'(IDLE_LIM)) begin
                cnt_q    <= '0;
                ack_pend <= 1'b0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    assign resp_oe = ack_pend;
endmodule

// File: rtl/lcdl_bus_seq.sv
module lcdl_bus_seq
    import lcdl_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int EN_CYC    = 12,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_t            frm,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [DATA_W-1:0] lcd_db,
    output logic              lcd_db_oe,
    output logic              lcd_en
);
    localparam int MAXC = (SETUP_CYC > EN_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((EN_CYC > HOLD_CYC) ? EN_CYC : HOLD_CYC);
    localparam int TW = $clog2(MAXC + 1);

    bus_st_e       st_q;
    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= BUS_IDLE;
            tcnt_q    <= '0;
            lcd_rs    <= 1'b0;
            lcd_rw    <= 1'b0;
            lcd_db    <= '0;
            lcd_db_oe <= 1'b0;
            lcd_en    <= 1'b0;
        end else begin
            case (st_q)
                BUS_IDLE: if (start) begin
                    lcd_rs    <= frm.rs;
                    lcd_rw    <= frm.rw;
                    lcd_db    <= frm.data;
                    lcd_db_oe <= ~frm.rw;
                    tcnt_q    <= '0;
                    st_q      <= BUS_SETUP;
                end
                BUS_SETUP: if (tcnt_q == TW'(SETUP_CYC - 1)) begin
                    lcd_en <= 1'b1;
                    tcnt_q <= '0;
                    st_q   <= BUS_PULSE;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
                BUS_PULSE: if (tcnt_q == TW'(EN_CYC - 1)) begin
                    lcd_en <= 1'b0;
                    tcnt_q <= '0;
                    st_q   <= BUS_HOLD;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
                BUS_HOLD: if (tcnt_q == TW'(HOLD_CYC - 1)) begin
                    tcnt_q <= '0;
                    st_q   <= BUS_IDLE;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
                default: st_q <= BUS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_link_rx.sv
module lcd_link_rx
    import lcdl_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int EN_CYC    = 12,
    parameter int HOLD_CYC  = 2,
    parameter int IDLE_LIM  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              resp_oe,
    output logic              resp_dat,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [DATA_W-1:0] lcd_db,
    output logic              lcd_db_oe,
    output logic              lcd_en,
    output logic              err_led
);
    logic   bit_rise;
    logic   bit_val;
    logic   frm_done;
    logic   frm_ok;
    frame_t frm;

    lcdl_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .bit_rise (bit_rise),
        .bit_val  (bit_val)
    );

    lcdl_frame_rx #(.IDLE_LIM(IDLE_LIM)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (bit_rise),
        .bit_val    (bit_val),
        .frame_done (frm_done),
        .frame_q    (frm),
        .par_ok     (frm_ok),
        .resp_oe    (resp_oe),
        .resp_dat   (resp_dat)
    );

    lcdl_bus_seq #(
        .SETUP_CYC (SETUP_CYC),
        .EN_CYC    (EN_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (frm_done & frm_ok),
        .frm       (frm),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_db    (lcd_db),
        .lcd_db_oe (lcd_db_oe),
        .lcd_en    (lcd_en)
    );

    always_ff @(posedge clk) begin
        if (rst)           err_led <= 1'b0;
        else if (frm_done) err_led <= ~frm_ok;
    end
endmodule

// File: rtl/lcd_link_rx_chk.sv
module lcd_link_rx_chk #(
    parameter int SETUP_CYC = 3,
    parameter int EN_CYC    = 12,
    parameter int HOLD_CYC  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic [7:0] lcd_db,
    input logic       lcd_db_oe,
    input logic       lcd_en,
    input logic       resp_oe,
    input logic       resp_dat,
    input logic       err_led,
    input logic       frame_done,
    input logic       par_ok
);
    logic [9:0] bus_now;
    logic [9:0] bus_prev;
    logic [7:0] stab;
    logic [7:0] en_len;
    logic [7:0] fall_age;
    logic [1:0] pend;
    logic       en_q;

    assign bus_now = {lcd_rs, lcd_rw, lcd_db};

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_prev <= '0;
            stab     <= '0;
            en_len   <= '0;
            fall_age <= 8'hFF;
            pend     <= '0;
            en_q     <= 1'b0;
        end else begin
            bus_prev <= bus_now;
            stab     <= (bus_now != bus_prev) ? 8'd0 : ((stab == 8'hFF) ? stab : stab + 8'd1);
            en_len   <= lcd_en ? en_len + 8'd1 : 8'd0;
            fall_age <= lcd_en ? 8'd0 : ((fall_age == 8'hFF) ? fall_age : fall_age + 8'd1);
            en_q     <= lcd_en;
            pend     <= pend + 2'((frame_done && par_ok) ? 1 : 0) - 2'((lcd_en && !en_q) ? 1 : 0);
        end
    end

    // R5
    setup_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> int'(stab) >= SETUP_CYC - 1);

    // R6
    enable_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> int'(en_len) == EN_CYC);

    // R7
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_now != bus_prev) |-> int'(fall_age) >= HOLD_CYC);

    // R4
    resp_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (resp_oe && resp_dat == $past(par_ok)));

    // R10
    err_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (err_led == !$past(par_ok)));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pend <= 2'd1);

    // R8
    pulse_has_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && !en_q) |-> pend != 2'd0);

    // R11
    db_drive_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> (lcd_db_oe == !lcd_rw));
endmodule

bind lcd_link_rx lcd_link_rx_chk #(
    .SETUP_CYC (SETUP_CYC),
    .EN_CYC    (EN_CYC),
    .HOLD_CYC  (HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_db     (lcd_db),
    .lcd_db_oe  (lcd_db_oe),
    .lcd_en     (lcd_en),
    .resp_oe    (resp_oe),
    .resp_dat   (resp_dat),
    .err_led    (err_led),
    .frame_done (frm_done),
    .par_ok     (frm_ok)
);

// File: tb/lcd_link_rx_tb.sv
module lcd_link_rx_tb;
    localparam int SETUP = 3;
    localparam int EN_W  = 6;
    localparam int HOLD  = 2;
    localparam int IDLE  = 40;
    localparam int HALF  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       resp_oe, resp_dat;
    logic       lcd_rs, lcd_rw, lcd_db_oe, lcd_en, err_led;
    logic [7:0] lcd_db;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    int en_w = 0;
    logic en_prev = 1'b0;
    logic [10:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    lcd_link_rx #(
        .SETUP_CYC (SETUP),
        .EN_CYC    (EN_W),
        .HOLD_CYC  (HOLD),
        .IDLE_LIM  (IDLE)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .resp_oe   (resp_oe),
        .resp_dat  (resp_dat),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_db    (lcd_db),
        .lcd_db_oe (lcd_db_oe),
        .lcd_en    (lcd_en),
        .err_led   (err_led)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_word(input logic sp, input logic rs, input logic rw,
                                            input logic [7:0] d, input logic bad);
        logic p;
        p = (^{sp, rs, rw, d}) ^ bad;
        return {sp, rs, rw, d, p};
    endfunction

    task automatic send_bits(input logic [11:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ser_clk = 1'b0;
            ser_dat = w[11-i];
            repeat (HALF) @(posedge clk);
            #1 ser_clk = 1'b1;
            repeat (HALF) @(posedge clk);
        end
    endtask

    // Full frame with response slot; scoreboard gets the good ones
    task automatic frame(input logic sp, input logic rs, input logic rw,
                         input logic [7:0] d, input logic bad);
        if (!bad) exp_q.push_back({rs, rw, ~rw, d});
        send_bits(mk_word(sp, rs, rw, d, bad), 12);
        #1 ser_clk = 1'b0;
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        chk(resp_oe == 1'b1, "R4 resp_oe up", int'(resp_oe), 1);
        chk(resp_dat == !bad, "R4 resp_dat", int'(resp_dat), int'(!bad));
        #1 ser_clk = 1'b1;
        repeat (HALF) @(posedge clk);
        #1 ser_clk = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(resp_oe == 1'b0, "R4 resp released", int'(resp_oe), 0);
        repeat (30) @(posedge clk);
    endtask

    // Monitor: scoreboard pops on each enable fall
    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_en) en_w++;
            if (en_prev && !lcd_en) begin
                pulses++;
                chk(en_w == EN_W, "R6 enable width", en_w, EN_W);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 pulse without frame", pulses, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk({lcd_rs, lcd_rw, lcd_db_oe, lcd_db} == e, "R2 R11 R12 replayed bus",
                        int'({lcd_rs, lcd_rw, lcd_db_oe, lcd_db}), int'(e));
                end
                en_w = 0;
            end
            en_prev = lcd_en;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk(lcd_en == 0, "R1 lcd_en", int'(lcd_en), 0);
        chk(resp_oe == 0, "R1 resp_oe", int'(resp_oe), 0);
        chk(err_led == 0, "R1 err_led", int'(err_led), 0);
        chk(lcd_db_oe == 0, "R1 lcd_db_oe", int'(lcd_db_oe), 0);

        // R2 command and data writes
        frame(1'b0, 1'b0, 1'b0, 8'hA5, 1'b0);
        @(negedge clk);
        chk(lcd_db == 8'hA5, "R2 data byte", int'(lcd_db), 'hA5);
        frame(1'b0, 1'b1, 1'b0, 8'h3C, 1'b0);

        // R12 spare bit set, same payload; R8 repeated frame still pulses
        p0 = pulses;
        frame(1'b1, 1'b1, 1'b0, 8'h3C, 1'b0);
        chk(pulses == p0 + 1, "R8 R12 repeat pulse", pulses, p0 + 1);

        // R11 read access
        frame(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        @(negedge clk);
        chk(lcd_db_oe == 1'b0, "R11 read drive off", int'(lcd_db_oe), 0);

        // R3 bad parity, R10 error set
        p0 = pulses;
        frame(1'b0, 1'b1, 1'b0, 8'hFF, 1'b1);
        @(negedge clk);
        chk(pulses == p0, "R3 no pulse", pulses, p0);
        chk(lcd_db == 8'h00 && lcd_rw == 1'b1, "R3 bus unchanged", int'({lcd_rw, lcd_db}), 'h100);
        chk(err_led == 1'b1, "R10 err set", int'(err_led), 1);

        // R10 cleared by good frame
        frame(1'b0, 1'b1, 1'b0, 8'h81, 1'b0);
        @(negedge clk);
        chk(err_led == 1'b0, "R10 err cleared", int'(err_led), 0);
        chk(lcd_db_oe == 1'b1, "R11 write drive on", int'(lcd_db_oe), 1);

        // R9 partial frame discarded
        send_bits(12'hFFF, 5);
        #1 ser_clk = 1'b0;
        repeat (100) @(posedge clk);
        frame(1'b0, 1'b1, 1'b0, 8'h42, 1'b0);
        @(negedge clk);
        chk(lcd_db == 8'h42, "R9 realigned after partial", int'(lcd_db), 'h42);

        // R9 unanswered response withdrawn
        exp_q.push_back({1'b0, 1'b0, 1'b1, 8'h5A});
        send_bits(mk_word(1'b0, 1'b0, 1'b0, 8'h5A, 1'b0), 12);
        #1 ser_clk = 1'b0;
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk(resp_oe == 1'b0, "R9 response withdrawn", int'(resp_oe), 0);
        frame(1'b0, 1'b0, 1'b0, 8'h01, 1'b0);

        repeat (50) @(posedge clk);
        chk(exp_q.size() == 0, "R8 all frames replayed", exp_q.size(), 0);
        chk(pulses == 8, "R8 pulse total", pulses, 8);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule